// File: doc/BRIEF.md
# DMA Channel Register Bank

This block is the software-visible control and status file of a 64-channel DMA engine. A processor reaches it through a simple 32-bit register bus. Each access carries a word address and four byte enables, and a read returns its data one cycle after it is accepted. For every channel the bank holds a request-enable bit, an error-interrupt-enable bit, an interrupt-pending bit, an error-pending bit and a done flag. Each 64-bit bitmap is split into a word for channels 63..32 and a word for channels 31..0. Eight byte-wide command lanes act on one channel per byte, or on every channel at once. Through them software can turn single bits on and off without a read-modify-write.

The transfer engine lives outside this block. It reports channel completions on `done_evt` and faults on `err_evt`, together with the channel number and a fault code. The bank latches the first fault into a global status word and keeps it until every pending error has been cleared. It drives one combined interrupt line and one-cycle start strobes towards the engine. It also holds a control word for clock gating and arbitration style, and a table of priority bytes, one per channel.

Two small state machines set the timing. The bus machine has two states. From `BUS_IDLE` a read is accepted and the machine moves to `BUS_READ` (transition *accept read*). `BUS_READ` presents the data and always returns to `BUS_IDLE` (transition *respond*). Writes complete in `BUS_IDLE` and leave the state unchanged. The error machine also has two states. `ESC_CLEAR` moves to `ESC_HELD` when a fault is captured (transition *capture*). `ESC_HELD` stays put while any error is pending and returns to `ESC_CLEAR` once none is pending and no new fault arrives (transition *release*).

Top module: `dma_chan_regbank`

## Requirements
- R1: After reset every register reads zero and all outputs are low, except `bus_ready`, which is high.
- R2: Word addresses 2 (channels 63..32) and 3 (channels 31..0) hold request enables. Addresses 4 and 5 hold error-interrupt enables in the same split. These words are read/write per byte lane. A read accepted in one cycle shows `bus_rvalid` and its data in the next cycle, and `bus_ready` is low during that cycle.
- R3: Word 6 holds the command lanes. Lane 0 (bits 7:0) sets a request enable, lane 1 clears one, lane 2 sets an error-interrupt enable and lane 3 clears one. Command bits 5:0 select the channel, bit 6 selects all channels and bit 7 is ignored. When a set and a clear hit the same bit in one write, the clear wins.
- R4: Both command words (6 and 7) read as zero.
- R5: Word 7 lane 0 clears a channel's interrupt-pending bit and lane 1 clears its error-pending bit. Neither touches the done flags.
- R6: Word 7 lane 2 raises `start_pulse` for the chosen channel or channels for exactly one cycle, in the cycle after the write is accepted. Word 7 lane 3 clears done flags (`ch_done`).
- R7: A `done_evt` bit sets that channel's interrupt-pending bit and done flag. An event beats a clear that hits the same bit in the same cycle.
- R8: Interrupt-pending words are at addresses 8 (channels 63..32) and 9 (channels 31..0), and error-pending words are at 10 and 11. Writing a one to an enabled byte clears the matching bit.
- R9: The error status word is at address 1: bit 31 valid, bit 15 `err_flags[9]`, bit 14 `err_flags[8]`, bits 13:8 the channel, bits 7:0 `err_flags[7:0]`. Each `err_evt` also sets that channel's error-pending bit. A fault that arrives while the word is valid does not overwrite it.
- R10: The valid bit clears in the cycle after no error-pending bit remains. A fault that arrives in the same cycle as the clearing of the last pending error does not replace the held word.
- R11: `irq` is high when any interrupt-pending bit is set, or when an error-pending bit is set and that channel's error-interrupt enable is also set.
- R12: The control word is at address 0. Only bit 31 (clock gating), bit 3 (round-robin group) and bit 2 (round-robin channel) are stored. They drive `clk_gate_en`, `rr_group_en` and `rr_chan_en`, and all other bits read zero.
- R13: Word addresses 64 to 79 hold the priority bytes. Byte lane k of word 64+n belongs to channel 4n+k. Any other address reads zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req | input | 1 | Access request |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_waddr | input | 7 | Word address (byte offset / 4) |
| bus_be | input | 4 | Byte enables, lane k = bits 8k+7..8k |
| bus_wdata | input | 32 | Write data |
| bus_ready | output | 1 | Bank can accept an access this cycle |
| bus_rvalid | output | 1 | Read data valid |
| bus_rdata | output | 32 | Read data |
| done_evt | input | 64 | Per-channel completion events |
| err_evt | input | 1 | Fault event |
| err_chan | input | 6 | Channel of the fault |
| err_flags | input | 10 | Fault code: group, channel priority, eight detail bits |
| req_en | output | 64 | Request enables |
| start_pulse | output | 64 | One-cycle start strobes |
| ch_done | output | 64 | Done flags |
| irq | output | 1 | Combined interrupt |
| clk_gate_en | output | 1 | Clock gating enable |
| rr_group_en | output | 1 | Round-robin group arbitration |
| rr_chan_en | output | 1 | Round-robin channel arbitration |

## Verification
The hardest case to reach from the ports is a new fault that lands in the same cycle as the software write that clears the last pending error. Any other ordering takes a different path through the error machine. The bench reaches it by driving the fault inputs in the very cycle the clearing write is accepted. It then reads back that the held status is unchanged while the new channel's pending bit is set. A done event raced against a clear command for the same channel, and a set/clear pair inside one write, are forced in the same way.

// File: rtl/dma_rb_pkg.sv
package dma_rb_pkg;
    localparam int NCH        = 64;
    localparam int CH_W       = 6;
    localparam int DW         = 32;
    localparam int PRIO_W     = 8;
    localparam int LANES      = DW / 8;
    localparam int PRIO_WORDS = NCH * PRIO_W / DW;

    // Word addresses
    localparam int W_CTRL   = 0;
    localparam int W_ESTAT  = 1;
    localparam int W_REQ_HI = 2;
    localparam int W_REQ_LO = 3;
    localparam int W_IE_HI  = 4;
    localparam int W_IE_LO  = 5;
    localparam int W_CMD_A  = 6;
    localparam int W_CMD_B  = 7;
    localparam int W_IP_HI  = 8;
    localparam int W_IP_LO  = 9;
    localparam int W_EP_HI  = 10;
    localparam int W_EP_LO  = 11;
    localparam int W_PRIO   = 64;

    // Command lane roles, index = 4 * (word - W_CMD_A) + lane
    localparam int L_SET_REQ  = 0;
    localparam int L_CLR_REQ  = 1;
    localparam int L_SET_IE   = 2;
    localparam int L_CLR_IE   = 3;
    localparam int L_CLR_INT  = 4;
    localparam int L_CLR_ERR  = 5;
    localparam int L_START    = 6;
    localparam int L_CLR_DONE = 7;
    localparam int N_CMD      = 8;

    // Control word bit positions
    localparam int CTL_GATE = 31;
    localparam int CTL_RRG  = 3;
    localparam int CTL_RRC  = 2;

    typedef enum logic {BUS_IDLE, BUS_READ} bus_state_t;
    typedef enum logic {ESC_CLEAR, ESC_HELD} esc_state_t;

    typedef struct packed {
        logic       grp;
        logic       chn;
        logic [7:0] detail;
    } err_flags_t;
endpackage

// File: rtl/dma_cmd_decode.sv
module dma_cmd_decode #(
    parameter int NCH  = 64,
    parameter int CH_W = 6
) (
    input  logic            en,
    input  logic [CH_W:0]   cmd,
    output logic [NCH-1:0]  mask
);
    // bit CH_W = broadcast to all channels, bits CH_W-1:0 = channel index
    for (genvar i = 0; i < NCH; i++) begin : g_sel
        assign mask[i] = en && (cmd[CH_W] || (cmd[CH_W-1:0] == CH_W'(i)));
    end
endmodule

// File: rtl/dma_chan_bitmap.sv
module dma_chan_bitmap #(
    parameter int NCH = 64,
    parameter int DW  = 32,
    parameter bit W1C = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_hi,
    input  logic              wr_lo,
    input  logic [DW/8-1:0]   be,
    input  logic [DW-1:0]     wdata,
    input  logic [NCH-1:0]    set_m,
    input  logic [NCH-1:0]    clr_m,
    input  logic [NCH-1:0]    evt_m,
    output logic [NCH-1:0]    q
);
    logic [NCH-1:0] d;

    for (genvar i = 0; i < NCH; i++) begin : g_bit
        localparam int BI = i % DW;
        localparam int LN = BI / 8;
        logic hit;
        logic base;
        assign hit = ((i >= DW) ? wr_hi : wr_lo) && be[LN];
        if (W1C) begin : g_w1c
            assign base = q[i] & ~(hit & wdata[BI]);
        end else begin : g_rw
            assign base = hit ? wdata[BI] : q[i];
        end
        // clear beats set, hardware event beats everything
        assign d[i] = ((base | set_m[i]) & ~clr_m[i]) | evt_m[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    p_evt_lands_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt_m) |=> ((q & $past(evt_m)) == $past(evt_m)));
endmodule

// File: rtl/dma_err_capture.sv
module dma_err_capture
    import dma_rb_pkg::*;
#(
    parameter int CHW = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             err_evt,
    input  logic [CHW-1:0]   err_chan,
    input  err_flags_t       err_flags,
    input  logic             pend_any,
    output logic [DW-1:0]    status
);
    esc_state_t state_q, state_d;
    logic       capture;

    // stale word (nothing pending) may be replaced by a fresh fault
    assign capture = err_evt && ((state_q == ESC_CLEAR) || !pend_any);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ESC_CLEAR;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ESC_CLEAR: if (capture) state_d = ESC_HELD;
            ESC_HELD:  if (!pend_any && !err_evt) state_d = ESC_CLEAR;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            status <= '0;
        end else if (capture) begin
            status <= {1'b1, 15'd0, err_flags.grp, err_flags.chn,
                       6'(err_chan), err_flags.detail};
        end else if (state_q == ESC_HELD && state_d == ESC_CLEAR) begin
            status <= '0;
        end
    end

    p_hold_while_pending_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ESC_HELD && err_evt && pend_any) |=> (status == $past(status)));

    p_valid_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (status[31] && !pend_any && !err_evt) |=> !status[31]);
endmodule

// File: rtl/dma_chan_regbank.sv
module dma_chan_regbank
    import dma_rb_pkg::*;
#(
    parameter int WADDR_W = 7
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_req,
    input  logic               bus_we,
    input  logic [WADDR_W-1:0] bus_waddr,
    input  logic [LANES-1:0]   bus_be,
    input  logic [DW-1:0]      bus_wdata,
    output logic               bus_ready,
    output logic               bus_rvalid,
    output logic [DW-1:0]      bus_rdata,
    input  logic [NCH-1:0]     done_evt,
    input  logic               err_evt,
    input  logic [CH_W-1:0]    err_chan,
    input  logic [9:0]         err_flags,
    output logic [NCH-1:0]     req_en,
    output logic [NCH-1:0]     start_pulse,
    output logic [NCH-1:0]     ch_done,
    output logic               irq,
    output logic               clk_gate_en,
    output logic               rr_group_en,
    output logic               rr_chan_en
);
    localparam int PIDX_W = $clog2(PRIO_WORDS);
    localparam logic [WADDR_W-1:0] A_CTRL   = WADDR_W'(W_CTRL);
    localparam logic [WADDR_W-1:0] A_ESTAT  = WADDR_W'(W_ESTAT);
    localparam logic [WADDR_W-1:0] A_REQ_HI = WADDR_W'(W_REQ_HI);
    localparam logic [WADDR_W-1:0] A_REQ_LO = WADDR_W'(W_REQ_LO);
    localparam logic [WADDR_W-1:0] A_IE_HI  = WADDR_W'(W_IE_HI);
    localparam logic [WADDR_W-1:0] A_IE_LO  = WADDR_W'(W_IE_LO);
    localparam logic [WADDR_W-1:0] A_IP_HI  = WADDR_W'(W_IP_HI);
    localparam logic [WADDR_W-1:0] A_IP_LO  = WADDR_W'(W_IP_LO);
    localparam logic [WADDR_W-1:0] A_EP_HI  = WADDR_W'(W_EP_HI);
    localparam logic [WADDR_W-1:0] A_EP_LO  = WADDR_W'(W_EP_LO);
    localparam logic [WADDR_W-1:0] A_PRIO   = WADDR_W'(W_PRIO);

    // ---------------- bus state machine ----------------
    bus_state_t bus_q, bus_d;
    logic       wr_fire, rd_fire;
    logic [DW-1:0] rd_val, rdata_q;

    assign wr_fire = bus_req &&  bus_we && (bus_q == BUS_IDLE);
    assign rd_fire = bus_req && !bus_we && (bus_q == BUS_IDLE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bus_q <= BUS_IDLE;
        else        bus_q <= bus_d;
    end

    always_comb begin
        bus_d = bus_q;
        unique case (bus_q)
            BUS_IDLE: if (rd_fire) bus_d = BUS_READ;
            BUS_READ: bus_d = BUS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       rdata_q <= '0;
        else if (rd_fire) rdata_q <= rd_val;
    end

    assign bus_ready  = (bus_q == BUS_IDLE);
    assign bus_rvalid = (bus_q == BUS_READ);
    assign bus_rdata  = rdata_q;

    // ---------------- command lanes ----------------
    logic [NCH-1:0] cmd_m [N_CMD];

    for (genvar k = 0; k < N_CMD; k++) begin : g_cmd
        localparam int LN = k % LANES;
        dma_cmd_decode #(.NCH(NCH), .CH_W(CH_W)) u_dec (
            .en   (wr_fire && (bus_waddr == WADDR_W'(W_CMD_A + k / LANES)) && bus_be[LN]),
            .cmd  (bus_wdata[8*LN +: CH_W+1]),
            .mask (cmd_m[k])
        );
    end

    // ---------------- per-channel bitmaps ----------------
    logic [NCH-1:0] ie_q, ip_q, ep_q, err_m;

    assign err_m = err_evt ? (NCH'(1) << err_chan) : '0;

    dma_chan_bitmap #(.NCH(NCH), .DW(DW), .W1C(1'b0)) u_req (
        .clk(clk), .rst_n(rst_n),
        .wr_hi(wr_fire && bus_waddr == A_REQ_HI), .wr_lo(wr_fire && bus_waddr == A_REQ_LO),
        .be(bus_be), .wdata(bus_wdata),
        .set_m(cmd_m[L_SET_REQ]), .clr_m(cmd_m[L_CLR_REQ]), .evt_m('0), .q(req_en)
    );

    dma_chan_bitmap #(.NCH(NCH), .DW(DW), .W1C(1'b0)) u_ie (
        .clk(clk), .rst_n(rst_n),
        .wr_hi(wr_fire && bus_waddr == A_IE_HI), .wr_lo(wr_fire && bus_waddr == A_IE_LO),
        .be(bus_be), .wdata(bus_wdata),
        .set_m(cmd_m[L_SET_IE]), .clr_m(cmd_m[L_CLR_IE]), .evt_m('0), .q(ie_q)
    );

    dma_chan_bitmap #(.NCH(NCH), .DW(DW), .W1C(1'b1)) u_ip (
        .clk(clk), .rst_n(rst_n),
        .wr_hi(wr_fire && bus_waddr == A_IP_HI), .wr_lo(wr_fire && bus_waddr == A_IP_LO),
        .be(bus_be), .wdata(bus_wdata),
        .set_m('0), .clr_m(cmd_m[L_CLR_INT]), .evt_m(done_evt), .q(ip_q)
    );

    dma_chan_bitmap #(.NCH(NCH), .DW(DW), .W1C(1'b1)) u_ep (
        .clk(clk), .rst_n(rst_n),
        .wr_hi(wr_fire && bus_waddr == A_EP_HI), .wr_lo(wr_fire && bus_waddr == A_EP_LO),
        .be(bus_be), .wdata(bus_wdata),
        .set_m('0), .clr_m(cmd_m[L_CLR_ERR]), .evt_m(err_m), .q(ep_q)
    );

    dma_chan_bitmap #(.NCH(NCH), .DW(DW), .W1C(1'b0)) u_done (
        .clk(clk), .rst_n(rst_n),
        .wr_hi(1'b0), .wr_lo(1'b0),
        .be(bus_be), .wdata(bus_wdata),
        .set_m('0), .clr_m(cmd_m[L_CLR_DONE]), .evt_m(done_evt), .q(ch_done)
    );

    // ---------------- start strobes ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) start_pulse <= '0;
        else        start_pulse <= cmd_m[L_START];
    end

    // ---------------- error capture ----------------
    err_flags_t    eflags;
    logic [DW-1:0] err_status;

    assign eflags = err_flags;

    dma_err_capture #(.CHW(CH_W)) u_esc (
        .clk(clk), .rst_n(rst_n),
        .err_evt(err_evt), .err_chan(err_chan), .err_flags(eflags),
        .pend_any(|ep_q), .status(err_status)
    );

    // ---------------- control word ----------------
    logic [2:0] ctrl_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (wr_fire && bus_waddr == A_CTRL) begin
            if (bus_be[CTL_GATE/8]) ctrl_q[2] <= bus_wdata[CTL_GATE];
            if (bus_be[CTL_RRG/8])  ctrl_q[1] <= bus_wdata[CTL_RRG];
            if (bus_be[CTL_RRC/8])  ctrl_q[0] <= bus_wdata[CTL_RRC];
        end
    end

    assign clk_gate_en = ctrl_q[2];
    assign rr_group_en = ctrl_q[1];
    assign rr_chan_en  = ctrl_q[0];

    // ---------------- priority bytes ----------------
    logic [NCH*PRIO_W-1:0] prio_flat;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prio_flat <= '0;
        end else if (wr_fire) begin
            for (int i = 0; i < NCH; i++) begin
                if (bus_waddr == WADDR_W'(W_PRIO + i / LANES) && bus_be[i % LANES])
                    prio_flat[i*PRIO_W +: PRIO_W] <= bus_wdata[(i % LANES)*8 +: PRIO_W];
            end
        end
    end

    // ---------------- interrupt ----------------
    assign irq = (|ip_q) || (|(ep_q & ie_q));

    // ---------------- read mux ----------------
    logic [WADDR_W-1:0] pidx;

    always_comb begin
        rd_val = '0;
        pidx   = bus_waddr - A_PRIO;
        if (bus_waddr >= A_PRIO && pidx < WADDR_W'(PRIO_WORDS)) begin
            rd_val = prio_flat[pidx[PIDX_W-1:0]*DW +: DW];
        end else begin
            case (bus_waddr)
                A_CTRL:   begin
                    rd_val[CTL_GATE] = ctrl_q[2];
                    rd_val[CTL_RRG]  = ctrl_q[1];
                    rd_val[CTL_RRC]  = ctrl_q[0];
                end
                A_ESTAT:  rd_val = err_status;
                A_REQ_HI: rd_val = req_en[NCH-1:DW];
                A_REQ_LO: rd_val = req_en[DW-1:0];
                A_IE_HI:  rd_val = ie_q[NCH-1:DW];
                A_IE_LO:  rd_val = ie_q[DW-1:0];
                A_IP_HI:  rd_val = ip_q[NCH-1:DW];
                A_IP_LO:  rd_val = ip_q[DW-1:0];
                A_EP_HI:  rd_val = ep_q[NCH-1:DW];
                A_EP_LO:  rd_val = ep_q[DW-1:0];
                default:  rd_val = '0;
            endcase
        end
    end

    // ---------------- assertions ----------------
    p_read_resp_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_we && bus_ready) |=> (bus_rvalid && !bus_ready));

    p_start_from_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (|start_pulse) |-> $past(wr_fire));

    p_done_raises_irq_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (|done_evt) |=> irq);
endmodule

// File: tb/test_dma_chan_regbank.sv
`timescale 1ns/1ps
module test_dma_chan_regbank;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_req = 1'b0, bus_we = 1'b0;
    logic [6:0]  bus_waddr = '0;
    logic [3:0]  bus_be = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_ready, bus_rvalid;
    logic [31:0] bus_rdata;
    logic [63:0] done_evt = '0;
    logic        err_evt = 1'b0;
    logic [5:0]  err_chan = '0;
    logic [9:0]  err_flags = '0;
    logic [63:0] req_en, start_pulse, ch_done;
    logic        irq, clk_gate_en, rr_group_en, rr_chan_en;

    always #2 clk = ~clk;

    dma_chan_regbank i_dma_chan_regbank (
        .clk(clk), .rst_n(rst_n),
        .bus_req(bus_req), .bus_we(bus_we), .bus_waddr(bus_waddr), .bus_be(bus_be),
        .bus_wdata(bus_wdata), .bus_ready(bus_ready), .bus_rvalid(bus_rvalid),
        .bus_rdata(bus_rdata), .done_evt(done_evt), .err_evt(err_evt),
        .err_chan(err_chan), .err_flags(err_flags), .req_en(req_en),
        .start_pulse(start_pulse), .ch_done(ch_done), .irq(irq),
        .clk_gate_en(clk_gate_en), .rr_group_en(rr_group_en), .rr_chan_en(rr_chan_en)
    );

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    typedef struct {
        string       tag;
        logic [6:0]  wa;
        logic [31:0] exp;
    } sb_item_t;
    sb_item_t sb_q[$];

    // side-band events applied in the same cycle as the next write
    logic [63:0] sb_done = '0;
    logic        sb_err = 1'b0;
    logic [5:0]  sb_chan = '0;
    logic [9:0]  sb_flags = '0;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [6:0] wa, input logic [3:0] be, input logic [31:0] d);
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b1; bus_waddr = wa; bus_be = be; bus_wdata = d;
        done_evt = sb_done; err_evt = sb_err; err_chan = sb_chan; err_flags = sb_flags;
        @(posedge clk);
        @(negedge clk);
        bus_req = 1'b0; bus_we = 1'b0; done_evt = '0; err_evt = 1'b0;
        sb_done = '0; sb_err = 1'b0;
    endtask

    task automatic evt(input logic [63:0] dv, input logic e, input logic [5:0] ch,
                       input logic [9:0] fl);
        @(negedge clk);
        done_evt = dv; err_evt = e; err_chan = ch; err_flags = fl;
        @(posedge clk);
        @(negedge clk);
        done_evt = '0; err_evt = 1'b0;
    endtask

    task automatic rd(input logic [6:0] wa, input logic [31:0] exp, input string tag);
        sb_item_t it;
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b0; bus_waddr = wa;
        it.tag = tag; it.wa = wa; it.exp = exp;
        sb_q.push_back(it);
        @(posedge clk);
        @(negedge clk);
        bus_req = 1'b0;
        chk("R2 ready low while responding", {63'd0, bus_ready}, 64'd0);
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (bus_rvalid) begin
            n_cmp++;
            if (sb_q.size() == 0) begin
                n_bad++;
                $display("FAIL R2 unexpected rvalid actual=%h expected=none", bus_rdata);
            end else begin
                sb_item_t it;
                it = sb_q.pop_front();
                if (bus_rdata !== it.exp) begin
                    n_bad++;
                    $display("FAIL %s addr=%0d actual=%h expected=%h",
                             it.tag, it.wa, bus_rdata, it.exp);
                end
            end
        end
    end

    initial begin
        repeat (60000) @(posedge clk);
        if (!finished) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1 reset state
        chk("R1 ready", {63'd0, bus_ready}, 64'd1);
        chk("R1 irq", {63'd0, irq}, 64'd0);
        chk("R1 req_en", req_en, 64'd0);
        chk("R1 start", start_pulse, 64'd0);
        chk("R1 done", ch_done, 64'd0);
        chk("R1 ctrl outs", {61'd0, clk_gate_en, rr_group_en, rr_chan_en}, 64'd0);
        for (int w = 0; w < 12; w++) rd(7'(w), 32'h0, "R1 reset read");

        // R2 word access with byte lanes
        wr(7'd3, 4'b0101, 32'hAABBCCDD);
        chk("R2 req lo lanes", {32'd0, req_en[31:0]}, 64'h00BB00DD);
        wr(7'd2, 4'hF, 32'h12345678);
        chk("R2 req full", req_en, 64'h12345678_00BB00DD);
        rd(7'd2, 32'h12345678, "R2 read req hi");
        rd(7'd3, 32'h00BB00DD, "R2 read req lo");

        // R3 set/clear commands
        wr(7'd6, 4'b0001, 32'h00000028);
        chk("R3 set req ch40", req_en, 64'h12345778_00BB00DD);
        wr(7'd6, 4'b0100, 32'h00400000);
        rd(7'd4, 32'hFFFFFFFF, "R3 set ie all hi");
        rd(7'd5, 32'hFFFFFFFF, "R3 set ie all lo");
        wr(7'd6, 4'b1000, 32'h03000000);
        rd(7'd5, 32'hFFFFFFF7, "R3 clr ie ch3");
        wr(7'd6, 4'b1100, 32'h05050000);
        rd(7'd5, 32'hFFFFFFD7, "R3 clear wins over set");
        wr(7'd6, 4'b0010, 32'h00004000);
        chk("R3 clear all req", req_en, 64'd0);
        wr(7'd6, 4'b0001, 32'h000000C0);
        chk("R3 bit7 ignored, all set", req_en, '1);
        wr(7'd6, 4'b0010, 32'h00004000);
        chk("R3 clear all again", req_en, 64'd0);

        // R4 command words read zero
        rd(7'd6, 32'h0, "R4 cmd word A");
        rd(7'd7, 32'h0, "R4 cmd word B");

        // R7 done event
        evt(64'd1 << 35, 1'b0, 6'd0, 10'd0);
        chk("R7 done flag", ch_done, 64'd1 << 35);
        chk("R11 irq from pending", {63'd0, irq}, 64'd1);
        rd(7'd8, 32'h00000008, "R7 ip hi");

        // R5 clear interrupt command
        wr(7'd7, 4'b0001, 32'h00000023);
        rd(7'd8, 32'h0, "R5 clr int");
        chk("R11 irq drops", {63'd0, irq}, 64'd0);
        chk("R5 done untouched", ch_done, 64'd1 << 35);

        // R6 clear done
        wr(7'd7, 4'b1000, 32'h23000000);
        chk("R6 clr done", ch_done, 64'd0);

        // R7 event beats same-cycle clear
        sb_done = 64'd1 << 2;
        wr(7'd7, 4'b0001, 32'h00000002);
        rd(7'd9, 32'h00000004, "R7 event beats clear");
        chk("R7 done set", ch_done, 64'd4);

        // R8 write-one-to-clear
        wr(7'd9, 4'hF, 32'h00000004);
        rd(7'd9, 32'h0, "R8 w1c");
        evt(64'h101, 1'b0, 6'd0, 10'd0);
        wr(7'd9, 4'b0001, 32'h00000101);
        rd(7'd9, 32'h00000100, "R8 w1c lane mask");
        wr(7'd9, 4'b0010, 32'h00000100);
        rd(7'd9, 32'h0, "R8 w1c lane1");
        wr(7'd7, 4'b1000, 32'h40000000);
        chk("R6 clr done all", ch_done, 64'd0);

        // R6 start pulses
        wr(7'd7, 4'b0100, 32'h00070000);
        chk("R6 start ch7", start_pulse, 64'd1 << 7);
        @(negedge clk);
        chk("R6 start one cycle", start_pulse, 64'd0);
        wr(7'd7, 4'b0100, 32'h00400000);
        chk("R6 start all", start_pulse, '1);
        @(negedge clk);
        chk("R6 start all one cycle", start_pulse, 64'd0);

        // R9 first error capture
        evt(64'd0, 1'b1, 6'd10, 10'h281);
        chk("R11 irq err enabled", {63'd0, irq}, 64'd1);
        rd(7'd1, 32'h80008A81, "R9 capture");
        rd(7'd11, 32'h00000400, "R9 ep set");
        evt(64'd0, 1'b1, 6'd3, 10'h102);
        rd(7'd1, 32'h80008A81, "R9 no overwrite");
        rd(7'd11, 32'h00000408, "R9 second ep");

        // R11 masking by error-interrupt enable
        wr(7'd7, 4'b0010, 32'h00000A00);
        rd(7'd11, 32'h00000008, "R5 clr err ch10");
        chk("R11 masked error", {63'd0, irq}, 64'd0);
        rd(7'd1, 32'h80008A81, "R10 still valid");
        wr(7'd6, 4'b0100, 32'h00030000);
        chk("R11 enable raises irq", {63'd0, irq}, 64'd1);

        // R10 release and re-capture
        wr(7'd11, 4'hF, 32'h00000008);
        rd(7'd11, 32'h0, "R10 ep cleared");
        rd(7'd1, 32'h0, "R10 valid dropped");
        chk("R11 irq low", {63'd0, irq}, 64'd0);
        evt(64'd0, 1'b1, 6'd63, 10'h001);
        rd(7'd1, 32'h80003F01, "R10 recapture");
        rd(7'd10, 32'h80000000, "R9 ep hi");
        sb_err = 1'b1; sb_chan = 6'd1; sb_flags = 10'h004;
        wr(7'd10, 4'hF, 32'h80000000);
        rd(7'd10, 32'h0, "R10 race ep hi");
        rd(7'd11, 32'h00000002, "R10 race ep lo");
        rd(7'd1, 32'h80003F01, "R10 race keeps word");
        wr(7'd11, 4'hF, 32'h00000002);
        rd(7'd1, 32'h0, "R10 release after race");
        evt(64'd0, 1'b1, 6'd5, 10'h010);
        rd(7'd1, 32'h80000510, "R9 fresh capture");

        // R12 control word
        wr(7'd0, 4'hF, 32'hFFFFFFFF);
        rd(7'd0, 32'h8000000C, "R12 ctrl read");
        chk("R12 ctrl outs", {61'd0, clk_gate_en, rr_group_en, rr_chan_en}, 64'd7);
        wr(7'd0, 4'b0111, 32'h0);
        rd(7'd0, 32'h80000000, "R12 lane3 kept");
        chk("R12 ctrl outs partial", {61'd0, clk_gate_en, rr_group_en, rr_chan_en}, 64'd4);

        // R13 priority bytes
        wr(7'd64, 4'hF, 32'h44332211);
        wr(7'd79, 4'b1000, 32'hAB000000);
        rd(7'd64, 32'h44332211, "R13 prio word 0");
        rd(7'd79, 32'hAB000000, "R13 prio ch63");
        rd(7'd65, 32'h0, "R13 prio untouched");
        rd(7'd80, 32'h0, "R13 beyond table");

        repeat (4) @(negedge clk);
        if (sb_q.size() != 0) begin
            n_cmp++; n_bad++;
            $display("FAIL R2 missing responses actual=%0d expected=0", sb_q.size());
        end
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule